// File: doc/BRIEF.md
# Master PCM Serial Audio Port

This block drives a two-channel serial voice link as the clock master. From the system clock it produces a bit clock and a frame sync. Each frame holds a first and a second channel slot of equal length. Once per frame it latches one transmit sample for each channel and shifts the samples out MSB first. On the same bit clock it shifts in the receive samples and presents both of them at once when the frame closes.

A four-bit control word is written through a single write strobe. The word sets the bit-clock edge used for launch and capture, how early the sync pulse rises before a channel change, the bit-clock rate, and a transmit mute. Writes go into a pending copy. That copy becomes live only when a frame wraps, so the clock and sync lines never see a change partway through a frame. An internal tick runs at twice the bit rate, so the sync edge can be placed half a bit period or one full bit period ahead of the boundary.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, `bclk`, `fsync`, `txd` and `rxValid` are low and all control bits are 0. The port then runs 16 bit clocks per frame with the default edge and sync placement.
- R2: With `ctlData[0]` (edge invert) at 0, `txd` changes only just after a rising edge of `bclk`, and `rxd` is sampled at the falling edge.
- R3: With `ctlData[0]` at 1, `txd` changes only just after a falling edge of `bclk`, and `rxd` is sampled at the rising edge.
- R4: With `ctlData[1]` (early sync) at 0, `fsync` rises half a bit-clock period, HALF_DIV system clocks, before the launch edge of the first bit of a frame.
- R5: With `ctlData[1]` at 1, `fsync` rises one full bit-clock period, 2*HALF_DIV system clocks, before that launch edge.
- R6: `ctlData[2]` (wide rate) selects 16 bit clocks per frame with 8-bit slots at 0, and 32 bit clocks per frame with 16-bit slots at 1. Data is sent MSB first, first channel before second. An 8-bit slot carries the top byte of the sample, and a received 8-bit slot appears in the top byte of its output with the low byte zero.
- R7: With `ctlData[3]` (transmit mute) at 1, `txd` stays low for the whole frame.
- R8: Both received samples are presented on `rxFirst`/`rxSecond` with a one-cycle `rxValid` pulse at each frame end. There is exactly one pulse per frame. Transmit samples are latched at frame start.
- R9: A control write made partway through a frame leaves that frame unchanged. The new setting applies from the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWe | input | 1 | Control write strobe |
| ctlData | input | 4 | Control word: [0] edge invert, [1] early sync, [2] wide rate, [3] transmit mute |
| txFirst | input | 16 | First-channel transmit sample |
| txSecond | input | 16 | Second-channel transmit sample |
| rxd | input | 1 | Serial receive data |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| txd | output | 1 | Serial transmit data |
| rxFirst | output | 16 | First-channel received sample |
| rxSecond | output | 16 | Second-channel received sample |
| rxValid | output | 1 | One-cycle pulse when received samples update |

## Verification
The transmit line is looped back to the receive line, and different, asymmetric samples are sent on the two channels. A byte-swap, a channel swap or a capture on the wrong edge therefore shows up as a wrong received word. All four combinations of edge polarity and sync placement are run across both rates. In each run, the bench counts launch edges between sync rises and measures the sync-to-launch delay, which separates the half-bit from the full-bit placement and 16 from 32 bit clocks. A mute run with all-ones samples must give a silent line and zero data. A rate change written partway through a frame must leave that frame at 16 bits and make the next frame 32.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef struct packed {
    logic txMute;
    logic wideRate;
    logic syncEarly;
    logic edgeInvert;
  } port_cfg_t;

  typedef struct packed {
    logic frameStart;
    logic frameEnd;
    logic launch;
    logic capture;
    logic wideEnd;
    logic wideNew;
    logic muteNow;
  } dp_strobe_t;

endpackage

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
  import pcm_port_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int DATA_W   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWe,
  input  port_cfg_t  ctlData,
  output logic       bclk,
  output logic       fsync,
  output port_cfg_t  liveCfg,
  output dp_strobe_t stb
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int PH_W  = $clog2(4 * DATA_W);

  function automatic logic [PH_W-1:0] lastHalf(input logic wide);
    return wide ? PH_W'(4 * DATA_W - 1) : PH_W'(2 * DATA_W - 1);
  endfunction

  logic [DIV_W-1:0] divCnt;
  logic [PH_W-1:0]  ph, nextPh, endPh;
  port_cfg_t        pendCfg, nextCfg;
  logic             firstFrame, tick, wrap, syncNext, bclkNext;

  always_comb begin
    tick     = (divCnt == DIV_W'(HALF_DIV - 1));
    wrap     = tick && (ph == lastHalf(liveCfg.wideRate));
    nextPh   = wrap ? '0 : ph + 1'b1;
    nextCfg  = wrap ? pendCfg : liveCfg;
    endPh    = lastHalf(nextCfg.wideRate);
    if (nextCfg.syncEarly) syncNext = (nextPh == endPh) || (nextPh == endPh - 1'b1);
    else                   syncNext = (nextPh == endPh) || (nextPh == '0);
    bclkNext = nextCfg.edgeInvert ? nextPh[0] : ~nextPh[0];

    stb.frameStart = wrap;
    stb.frameEnd   = wrap && !firstFrame;
    stb.launch     = tick && !wrap && !nextPh[0];
    stb.capture    = tick && nextPh[0];
    stb.wideEnd    = liveCfg.wideRate;
    stb.wideNew    = nextCfg.wideRate;
    stb.muteNow    = nextCfg.txMute;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt     <= '0;
      ph         <= lastHalf(1'b0);
      pendCfg    <= '0;
      liveCfg    <= '0;
      firstFrame <= 1'b1;
      bclk       <= 1'b0;
      fsync      <= 1'b0;
    end else begin
      if (ctlWe) pendCfg <= ctlData;
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        ph      <= nextPh;
        liveCfg <= nextCfg;
        bclk    <= bclkNext;
        fsync   <= syncNext;
        if (wrap) firstFrame <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pcm_port_dp.sv
module pcm_port_dp
  import pcm_port_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        stb,
  input  logic [DATA_W-1:0] txFirst,
  input  logic [DATA_W-1:0] txSecond,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] rxFirst,
  output logic [DATA_W-1:0] rxSecond,
  output logic              rxValid
);

  localparam int SH_W = 2 * DATA_W;
  localparam int HALF = DATA_W / 2;

  logic [SH_W-1:0] txSh, rxSh, txPacked;

  always_comb begin
    if (stb.wideNew) txPacked = {txFirst, txSecond};
    else txPacked = {txFirst[DATA_W-1 -: HALF], txSecond[DATA_W-1 -: HALF], {DATA_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh     <= '0;
      rxSh     <= '0;
      txd      <= 1'b0;
      rxFirst  <= '0;
      rxSecond <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= stb.frameEnd;
      if (stb.frameStart) begin
        txSh <= txPacked;
        txd  <= stb.muteNow ? 1'b0 : txPacked[SH_W-1];
      end else if (stb.launch) begin
        txSh <= txSh << 1;
        txd  <= stb.muteNow ? 1'b0 : txSh[SH_W-2];
      end
      if (stb.capture) rxSh <= {rxSh[SH_W-2:0], rxd};
      if (stb.frameEnd) begin
        if (stb.wideEnd) begin
          rxFirst  <= rxSh[SH_W-1 -: DATA_W];
          rxSecond <= rxSh[DATA_W-1:0];
        end else begin
          rxFirst  <= {rxSh[DATA_W-1 -: HALF], {HALF{1'b0}}};
          rxSecond <= {rxSh[HALF-1:0], {HALF{1'b0}}};
        end
      end
    end
  end

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWe,
  input  logic [3:0]        ctlData,
  input  logic [DATA_W-1:0] txFirst,
  input  logic [DATA_W-1:0] txSecond,
  input  logic              rxd,
  output logic              bclk,
  output logic              fsync,
  output logic              txd,
  output logic [DATA_W-1:0] rxFirst,
  output logic [DATA_W-1:0] rxSecond,
  output logic              rxValid
);

  port_cfg_t  liveCfg;
  dp_strobe_t stb;

  pcm_port_ctrl #(.HALF_DIV(HALF_DIV), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWe(ctlWe), .ctlData(port_cfg_t'(ctlData)),
    .bclk(bclk), .fsync(fsync), .liveCfg(liveCfg), .stb(stb)
  );

  pcm_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txFirst(txFirst), .txSecond(txSecond),
    .rxd(rxd), .txd(txd), .rxFirst(rxFirst), .rxSecond(rxSecond), .rxValid(rxValid)
  );

endmodule

// File: rtl/pcm_port_checker.sv
module pcm_port_checker
  import pcm_port_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       bclk,
  input logic       fsync,
  input logic       txd,
  input logic       rxValid,
  input port_cfg_t  liveCfg,
  input dp_strobe_t stb
);

  AST_TXD_ON_BCLK_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $changed(txd) |-> ($changed(bclk) || $past(stb.frameStart)));   // R2

  AST_MUTE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    liveCfg.txMute |-> !txd);   // R7

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);   // R8

  AST_SYNC_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fsync) |-> ($changed(bclk) || $past(stb.frameStart)));   // R4

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.frameStart) |-> $stable(liveCfg));   // R9

endmodule

bind pcm_serial_port pcm_port_checker u_chk (
  .clk(clk), .rstN(rstN), .bclk(bclk), .fsync(fsync), .txd(txd),
  .rxValid(rxValid), .liveCfg(liveCfg), .stb(stb)
);

// File: tb/pcm_serial_port_bench.sv
`timescale 1ns/1ps
module pcm_serial_port_bench;

  localparam int HD = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWe = 1'b0;
  logic [3:0]  ctlData = '0;
  logic [15:0] txFirst = '0, txSecond = '0;
  logic        rxd, bclk, fsync, txd, rxValid;
  logic [15:0] rxFirst, rxSecond;

  assign rxd = txd;   // loopback

  pcm_serial_port #(.HALF_DIV(HD), .DATA_W(16)) u_pcm_serial_port (
    .clk(clk), .rstN(rstN), .ctlWe(ctlWe), .ctlData(ctlData), .txFirst(txFirst),
    .txSecond(txSecond), .rxd(rxd), .bclk(bclk), .fsync(fsync), .txd(txd),
    .rxFirst(rxFirst), .rxSecond(rxSecond), .rxValid(rxValid)
  );

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit expPol = 1'b0;
  int cyc = 0, launchCnt = 0, lastCount = 0, syncT = 0, lastGap = 0;
  int syncRises = 0, viol = 0, txdHigh = 0, validCount = 0;
  bit gapPending = 1'b0, prevB = 1'b0, prevSync = 1'b0, prevTxd = 1'b0;
  logic [15:0] lastRxA = '0, lastRxB = '0;

  always @(negedge clk) begin
    bit launchEdge;
    cyc++;
    if (rstN) begin
      launchEdge = expPol ? (prevB && !bclk) : (!prevB && bclk);
      if (launchEdge) begin
        launchCnt++;
        if (gapPending) begin lastGap = cyc - syncT; gapPending = 1'b0; end
      end
      if (txd !== prevTxd && !launchEdge) viol++;
      if (txd) txdHigh++;
      if (fsync && !prevSync) begin
        lastCount = launchCnt; launchCnt = 0; syncT = cyc; gapPending = 1'b1; syncRises++;
      end
      if (rxValid) begin lastRxA = rxFirst; lastRxB = rxSecond; validCount++; end
    end
    prevB = bclk; prevSync = fsync; prevTxd = txd;
  end

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitSync(int n);
    int target = syncRises + n;
    while (syncRises < target) begin @(negedge clk); #1; end
  endtask

  task automatic writeCfg(logic [3:0] v);
    @(negedge clk); #1; ctlWe = 1'b1; ctlData = v;
    @(negedge clk); #1; ctlWe = 1'b0;
  endtask

  task automatic testReset();
    check("R1 bclk", bclk, 0);
    check("R1 fsync", fsync, 0);
    check("R1 txd", txd, 0);
    check("R1 rxValid", rxValid, 0);
  endtask

  task automatic testDefaults();
    waitSync(4);
    check("R1 bits per frame", lastCount, 16);
    check("R1 sync gap", lastGap, HD);
  endtask

  task automatic runMode(logic [3:0] v, logic [15:0] a, logic [15:0] b);
    bit wide = v[2], early = v[1], mute = v[3];
    int vc;
    logic [15:0] ea, eb;
    txFirst = a; txSecond = b;
    writeCfg(v);
    expPol = v[0];
    waitSync(3);
    viol = 0; txdHigh = 0; vc = validCount;
    waitSync(3);
    check(v[0] ? "R3 launch edge" : "R2 launch edge", viol, 0);
    check("R6 bits per frame", lastCount, wide ? 32 : 16);
    check(early ? "R5 sync gap" : "R4 sync gap", lastGap, early ? 2 * HD : HD);
    check("R8 valid per frame", validCount - vc, 3);
    ea = mute ? 16'h0 : (wide ? a : {a[15:8], 8'h00});
    eb = mute ? 16'h0 : (wide ? b : {b[15:8], 8'h00});
    check(v[0] ? "R3 rx first" : "R6 rx first", lastRxA, ea);
    check("R8 rx second", lastRxB, eb);
    if (mute) check("R7 txd high samples", txdHigh, 0);
  endtask

  task automatic testBoundary();
    txFirst = 16'h1234; txSecond = 16'hFEDC;
    writeCfg(4'b0000); expPol = 1'b0;
    waitSync(3);
    repeat (10) @(negedge clk);
    #1; ctlWe = 1'b1; ctlData = 4'b0100;
    @(negedge clk); #1; ctlWe = 1'b0;
    waitSync(1);
    check("R9 frame with write", lastCount, 16);
    waitSync(1);
    check("R9 frame after write", lastCount, 32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    testDefaults();
    runMode(4'b0000, 16'hA5C3, 16'h3C96);
    runMode(4'b0011, 16'h81E7, 16'h5A0F);
    runMode(4'b0110, 16'hC0DE, 16'h1B2D);
    runMode(4'b0101, 16'h6E35, 16'hD249);
    runMode(4'b1101, 16'hFFFF, 16'hFFFF);
    testBoundary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule